// File: doc/BRIEF.md
# Iterative Triple DES engine

The block runs one 64-bit block through Triple DES in encrypt-decrypt-encrypt form. Only one DES round is built in hardware. It is used once per clock, so the three chained DES passes take 48 rounds in total. The block sequences the passes itself. Each pass gets its own direction and its own subkey order. The key for the next pass is loaded into the key schedule during the last round of the current pass, so no cycle is lost between passes.

The host pulses `start_i` for one cycle and presents the operation at the same time: the direction bit, the keying option, three 64-bit keys and the data block. All of these are captured on the accepting edge. The result comes out on `data_o` together with a one-cycle `done_o` pulse, and `data_o` keeps that value until the next result replaces it. A new operation with a different key or direction can be accepted in the last round cycle of the running one, so operations can run back to back with one start every 48 cycles.

Top module: `tdes_core`

## Requirements
- R1: With `encrypt_i`=1 and `key_mode_i`=2'b00, `data_o` equals E(key3, D(key2, E(key1, data_i))). E and D are single-DES encryption and decryption. Bit 63 of every 64-bit port is DES bit 1.
- R2: With `encrypt_i`=0, `data_o` equals D(key1, E(key2, D(key3, data_i))), using the effective keys of the selected keying option.
- R3: With `key_mode_i`=2'b01, key1 takes the place of key3, so the value of `key3_i` has no effect on `data_o`.
- R4: With `key_mode_i`=2'b10 or 2'b11, the result is single DES with `key1_i` in the selected direction, and `key2_i` and `key3_i` have no effect.
- R5: The parity bit of each key byte (port bits 0, 8, 16, ..., 56) has no effect on the result.
- R6: `done_o` is high for exactly one cycle. It rises 48 clock edges after the edge that accepted `start_i`, and `data_o` holds the finished result in that cycle.
- R7: `data_o` changes only in a cycle where `done_o` is high, and keeps its value between results.
- R8: A `start_i` seen while an operation is running is ignored, except in the running operation's last round cycle. There it is accepted with its own key and mode, and its result follows 48 cycles after the first result.
- R9: After reset, `done_o` is 0 and `data_o` is all zeros.
- R10: The data, keys, direction and keying option are sampled only on the accepting edge. Changes to them during an operation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| encrypt_i | input | 1 | 1 = encrypt, 0 = decrypt |
| key_mode_i | input | 2 | 00 three keys, 01 two keys (K3=K1), 1x single key |
| key1_i | input | 64 | First key, parity bits ignored |
| key2_i | input | 64 | Second key |
| key3_i | input | 64 | Third key |
| data_i | input | 64 | Input block |
| data_o | output | 64 | Result block |
| done_o | output | 1 | Result-valid strobe |

## Verification
The block has no free parameters: block width, round count and pass count are fixed package constants, so the bench builds it at those values. That puts the full 48-cycle sequence within reach on every operation, including both direction changes between passes and the key reload at each pass boundary. Random operations cover all keying options and both directions and are compared with an independent bench model. Fixed single-DES answer vectors check the round logic apart from that model. Directed runs cover a start arriving mid-operation, a start arriving in the last round cycle, and inputs changing after acceptance.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

  localparam int BLK_W     = 64;
  localparam int HALF_W    = BLK_W / 2;
  localparam int CD_W      = 56;
  localparam int CD_HALF_W = CD_W / 2;
  localparam int SUBKEY_W  = 48;
  localparam int NUM_SBOX  = 8;
  localparam int ROUNDS    = 16;
  localparam int PASSES    = 3;
  localparam int LATENCY   = ROUNDS * PASSES;
  localparam int RND_W     = $clog2(ROUNDS);
  localparam int PASS_W    = $clog2(PASSES);

  typedef enum logic [1:0] {
    KEYS_THREE = 2'b00,
    KEYS_TWO   = 2'b01,
    KEYS_ONE   = 2'b10,
    KEYS_ONE_B = 2'b11
  } key_mode_e;

  localparam int IP_T [64] = '{
    58,50,42,34,26,18,10,2,60,52,44,36,28,20,12,4,
    62,54,46,38,30,22,14,6,64,56,48,40,32,24,16,8,
    57,49,41,33,25,17,9,1,59,51,43,35,27,19,11,3,
    61,53,45,37,29,21,13,5,63,55,47,39,31,23,15,7};
  localparam int E_T [48] = '{
    32,1,2,3,4,5,4,5,6,7,8,9,8,9,10,11,12,13,12,13,14,15,16,17,
    16,17,18,19,20,21,20,21,22,23,24,25,24,25,26,27,28,29,28,29,30,31,32,1};
  localparam int P_T [32] = '{
    16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,
    2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};
  localparam int PC1_T [56] = '{
    57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,60,52,44,36,
    63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int PC2_T [48] = '{
    14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
    41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

  localparam int SB0 [64] = '{
    14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7, 0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
    4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0, 15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam int SB1 [64] = '{
    15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10, 3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
    0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15, 13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam int SB2 [64] = '{
    10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8, 13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
    13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7, 1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam int SB3 [64] = '{
    7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15, 13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
    10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4, 3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam int SB4 [64] = '{
    2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9, 14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
    4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14, 11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam int SB5 [64] = '{
    12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11, 10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
    9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6, 4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam int SB6 [64] = '{
    4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1, 13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
    1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2, 6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam int SB7 [64] = '{
    13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7, 1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
    7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8, 2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  // table entries count from the MSB, starting at 1
  function automatic logic [BLK_W-1:0] init_perm(logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] o;
    for (int i = 0; i < BLK_W; i++) o[6'(BLK_W-1-i)] = x[6'(BLK_W-IP_T[i])];
    return o;
  endfunction

  // inverse of the initial permutation
  function automatic logic [BLK_W-1:0] final_perm(logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] o;
    for (int i = 0; i < BLK_W; i++) o[6'(BLK_W-IP_T[i])] = x[6'(BLK_W-1-i)];
    return o;
  endfunction

  function automatic logic [SUBKEY_W-1:0] expand(logic [HALF_W-1:0] r);
    logic [SUBKEY_W-1:0] o;
    for (int i = 0; i < SUBKEY_W; i++) o[6'(SUBKEY_W-1-i)] = r[5'(HALF_W-E_T[i])];
    return o;
  endfunction

  function automatic logic [HALF_W-1:0] pbox(logic [HALF_W-1:0] s);
    logic [HALF_W-1:0] o;
    for (int i = 0; i < HALF_W; i++) o[5'(HALF_W-1-i)] = s[5'(HALF_W-P_T[i])];
    return o;
  endfunction

  function automatic logic [CD_W-1:0] key_pc1(logic [BLK_W-1:0] k);
    logic [CD_W-1:0] o;
    for (int i = 0; i < CD_W; i++) o[6'(CD_W-1-i)] = k[6'(BLK_W-PC1_T[i])];
    return o;
  endfunction

  function automatic logic [SUBKEY_W-1:0] key_pc2(logic [CD_W-1:0] cd);
    logic [SUBKEY_W-1:0] o;
    for (int i = 0; i < SUBKEY_W; i++) o[6'(SUBKEY_W-1-i)] = cd[6'(CD_W-PC2_T[i])];
    return o;
  endfunction

  function automatic logic [3:0] sbox(int n, logic [5:0] x);
    logic [5:0] idx;
    idx = {x[5], x[0], x[4:1]};
    case (n)
      0: return 4'(SB0[idx]);
      1: return 4'(SB1[idx]);
      2: return 4'(SB2[idx]);
      3: return 4'(SB3[idx]);
      4: return 4'(SB4[idx]);
      5: return 4'(SB5[idx]);
      6: return 4'(SB6[idx]);
      default: return 4'(SB7[idx]);
    endcase
  endfunction

  // rotation step of the round about to run; decrypt walks the schedule backwards
  function automatic logic [1:0] rot_amt(logic enc, logic [RND_W-1:0] rnd);
    logic one_step;
    one_step = (rnd == RND_W'(1)) || (rnd == RND_W'(8)) || (rnd == RND_W'(ROUNDS-1));
    if (enc) return (one_step || rnd == '0) ? 2'd1 : 2'd2;
    if (rnd == '0) return 2'd0;
    return one_step ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [CD_HALF_W-1:0] rot_half(logic [CD_HALF_W-1:0] c,
                                                   logic [1:0] amt, logic left);
    case (amt)
      2'd1:    return left ? {c[CD_HALF_W-2:0], c[CD_HALF_W-1]}
                           : {c[0], c[CD_HALF_W-1:1]};
      2'd2:    return left ? {c[CD_HALF_W-3:0], c[CD_HALF_W-1:CD_HALF_W-2]}
                           : {c[1:0], c[CD_HALF_W-1:2]};
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/tdes_feistel.sv
module tdes_feistel
  import tdes_pkg::*;
(
  input  logic [HALF_W-1:0]   r_i,
  input  logic [SUBKEY_W-1:0] subkey_i,
  output logic [HALF_W-1:0]   f_o
);

  logic [SUBKEY_W-1:0] mixed;
  logic [HALF_W-1:0]   sub_out;

  assign mixed = expand(r_i) ^ subkey_i;

  for (genvar j = 0; j < NUM_SBOX; j++) begin : g_sbox
    assign sub_out[HALF_W-1-4*j -: 4] = sbox(j, mixed[SUBKEY_W-1-6*j -: 6]);
  end

  assign f_o = pbox(sub_out);

endmodule

// File: rtl/tdes_key_sched.sv
module tdes_key_sched
  import tdes_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [CD_W-1:0]     load_key_i,
  input  logic                reload_i,
  input  logic [CD_W-1:0]     reload_key_i,
  input  logic                busy_i,
  input  logic                enc_pass_i,
  input  logic [RND_W-1:0]    rnd_i,
  output logic [SUBKEY_W-1:0] subkey_o
);

  logic [CD_HALF_W-1:0] c_q, d_q, c_rot, d_rot;
  logic [1:0]           amt;

  assign amt   = rot_amt(enc_pass_i, rnd_i);
  assign c_rot = rot_half(c_q, amt, enc_pass_i);
  assign d_rot = rot_half(d_q, amt, enc_pass_i);
  assign subkey_o = key_pc2({c_rot, d_rot});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      {c_q, d_q} <= load_key_i;
    end else if (reload_i) begin
      {c_q, d_q} <= reload_key_i;
    end else if (busy_i) begin
      c_q <= c_rot;
      d_q <= d_rot;
    end
  end

endmodule

// File: rtl/tdes_seq.sv
module tdes_seq
  import tdes_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [RND_W-1:0]  rnd_o,
  output logic [PASS_W-1:0] pass_o,
  output logic              last_rnd_o,
  output logic              final_o
);

  logic              busy_q;
  logic [RND_W-1:0]  rnd_q;
  logic [PASS_W-1:0] pass_q;

  assign last_rnd_o = rnd_q == RND_W'(ROUNDS-1);
  assign final_o    = busy_q && last_rnd_o && pass_q == PASS_W'(PASSES-1);
  // the last round cycle may hand over to the next operation
  assign accept_o   = start_i && (!busy_q || final_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      pass_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      rnd_q  <= '0;
      pass_q <= '0;
    end else if (busy_q) begin
      if (last_rnd_o) begin
        rnd_q <= '0;
        if (pass_q == PASS_W'(PASSES-1)) busy_q <= 1'b0;
        else                             pass_q <= pass_q + 1'b1;
      end else begin
        rnd_q <= rnd_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign rnd_o  = rnd_q;
  assign pass_o = pass_q;

endmodule

// File: rtl/tdes_core.sv
module tdes_core
  import tdes_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             encrypt_i,
  input  logic [1:0]       key_mode_i,
  input  logic [BLK_W-1:0] key1_i,
  input  logic [BLK_W-1:0] key2_i,
  input  logic [BLK_W-1:0] key3_i,
  input  logic [BLK_W-1:0] data_i,
  output logic [BLK_W-1:0] data_o,
  output logic             done_o
);

  logic              accept, busy, last_rnd, final_rnd, enc_q, enc_pass, reload, done_q;
  logic [RND_W-1:0]  rnd;
  logic [PASS_W-1:0] pass;
  logic [BLK_W-1:0]  k2_eff, k3_eff, key_first, key_last, res_q;
  logic [CD_W-1:0]   pk1_q, pk2_q;
  logic [HALF_W-1:0] l_q, r_q, f;
  logic [SUBKEY_W-1:0] subkey;

  tdes_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .accept_o  (accept),
    .busy_o    (busy),
    .rnd_o     (rnd),
    .pass_o    (pass),
    .last_rnd_o(last_rnd),
    .final_o   (final_rnd)
  );

  // keying option resolved at start; decrypt uses the keys in reverse order
  always_comb begin
    k2_eff    = key_mode_i[1] ? key1_i : key2_i;
    k3_eff    = (key_mode_e'(key_mode_i) == KEYS_THREE) ? key3_i : key1_i;
    key_first = encrypt_i ? key1_i : k3_eff;
    key_last  = encrypt_i ? k3_eff : key1_i;
  end

  // middle pass runs opposite to the outer ones
  assign enc_pass = enc_q ^ (pass == PASS_W'(1));
  assign reload   = busy && last_rnd && !final_rnd;

  tdes_key_sched i_key_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_key_i  (key_pc1(key_first)),
    .reload_i    (reload),
    .reload_key_i(pass == '0 ? pk1_q : pk2_q),
    .busy_i      (busy),
    .enc_pass_i  (enc_pass),
    .rnd_i       (rnd),
    .subkey_o    (subkey)
  );

  tdes_feistel i_feistel (
    .r_i     (r_q),
    .subkey_i(subkey),
    .f_o     (f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_q <= 1'b0;
      pk1_q <= '0;
      pk2_q <= '0;
    end else if (accept) begin
      enc_q <= encrypt_i;
      pk1_q <= key_pc1(k2_eff);
      pk2_q <= key_pc1(key_last);
    end
  end

  // last round of a pass stores the halves unswapped: FP then IP cancel between passes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q <= '0;
      r_q <= '0;
    end else if (accept) begin
      {l_q, r_q} <= init_perm(data_i);
    end else if (busy) begin
      if (last_rnd) begin
        l_q <= l_q ^ f;
      end else begin
        l_q <= r_q;
        r_q <= l_q ^ f;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_rnd;
      if (final_rnd) res_q <= final_perm({l_q ^ f, r_q});
    end
  end

  assign data_o = res_q;
  assign done_o = done_q;

endmodule

// File: rtl/tdes_core_chk.sv
module tdes_core_chk
  import tdes_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [BLK_W-1:0]  data_o,
  input logic              busy,
  input logic [RND_W-1:0]  rnd,
  input logic [PASS_W-1:0] pass
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  // cycles into the running operation, 0 when idle
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                  run_cnt <= '0;
    else if (start_i && (run_cnt == '0 || run_cnt == CNT_W'(LATENCY))) run_cnt <= CNT_W'(1);
    else if (run_cnt == CNT_W'(LATENCY))                          run_cnt <= '0;
    else if (run_cnt != '0)                                       run_cnt <= run_cnt + 1'b1;
  end

  AST_DONE_AFTER_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt == CNT_W'(LATENCY) |=> done_o); // R6
  AST_DONE_ONLY_AT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(run_cnt) == CNT_W'(LATENCY)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o)); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy && !(rnd == RND_W'(ROUNDS-1) && pass == PASS_W'(PASSES-1))
    |=> !(rnd == '0 && pass == '0)); // R8
  AST_BUSY_TRACKS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy == (run_cnt != '0)); // R8

endmodule

bind tdes_core tdes_core_chk i_tdes_core_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .done_o (done_o),
  .data_o (data_o),
  .busy   (busy),
  .rnd    (rnd),
  .pass   (pass)
);

// File: tb/test_tdes_core.sv
module test_tdes_core;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, encrypt_i = 1'b0;
  logic [1:0]  key_mode_i = '0;
  logic [63:0] key1_i = '0, key2_i = '0, key3_i = '0, data_i = '0;
  logic [63:0] data_o;
  logic        done_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  tdes_core i_tdes_core (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  // ---------------- reference model ----------------
  localparam int M_IP [64] = '{58,50,42,34,26,18,10,2,60,52,44,36,28,20,12,4,62,54,46,38,30,22,14,6,
    64,56,48,40,32,24,16,8,57,49,41,33,25,17,9,1,59,51,43,35,27,19,11,3,61,53,45,37,29,21,13,5,63,55,47,39,31,23,15,7};
  localparam int M_FP [64] = '{40,8,48,16,56,24,64,32,39,7,47,15,55,23,63,31,38,6,46,14,54,22,62,30,
    37,5,45,13,53,21,61,29,36,4,44,12,52,20,60,28,35,3,43,11,51,19,59,27,34,2,42,10,50,18,58,26,33,1,41,9,49,17,57,25};
  localparam int M_E [48] = '{32,1,2,3,4,5,4,5,6,7,8,9,8,9,10,11,12,13,12,13,14,15,16,17,
    16,17,18,19,20,21,20,21,22,23,24,25,24,25,26,27,28,29,28,29,30,31,32,1};
  localparam int M_P [32] = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};
  localparam int M_PC1 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,60,52,44,36,
    63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  localparam int M_PC2 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
    41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
  localparam int M_S1 [64] = '{14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
    4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam int M_S2 [64] = '{15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
    0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam int M_S3 [64] = '{10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
    13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam int M_S4 [64] = '{7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
    10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam int M_S5 [64] = '{2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
    4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam int M_S6 [64] = '{12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
    9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam int M_S7 [64] = '{4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
    1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam int M_S8 [64] = '{13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
    7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  function automatic int m_sbox(int n, int v);
    int ix = ((v >> 4) & 2) | (v & 1);
    ix = ix * 16 + ((v >> 1) & 15);
    case (n)
      0: return M_S1[ix]; 1: return M_S2[ix]; 2: return M_S3[ix]; 3: return M_S4[ix];
      4: return M_S5[ix]; 5: return M_S6[ix]; 6: return M_S7[ix]; default: return M_S8[ix];
    endcase
  endfunction

  function automatic logic [63:0] m_des(logic [63:0] key, logic [63:0] blk, bit enc);
    logic [27:0] c, d;
    logic [55:0] cd;
    logic [47:0] ks [16];
    logic [63:0] x, y;
    logic [31:0] l, r, t, s, p;
    logic [47:0] e;
    for (int i = 0; i < 56; i++) cd[55-i] = key[64-M_PC1[i]];
    c = cd[55:28]; d = cd[27:0];
    for (int rd = 0; rd < 16; rd++) begin
      int sh = (rd == 0 || rd == 1 || rd == 8 || rd == 15) ? 1 : 2;
      for (int k = 0; k < sh; k++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
      cd = {c, d};
      for (int i = 0; i < 48; i++) ks[rd][47-i] = cd[56-M_PC2[i]];
    end
    for (int i = 0; i < 64; i++) x[63-i] = blk[64-M_IP[i]];
    l = x[63:32]; r = x[31:0];
    for (int rd = 0; rd < 16; rd++) begin
      for (int i = 0; i < 48; i++) e[47-i] = r[32-M_E[i]];
      e = e ^ (enc ? ks[rd] : ks[15-rd]);
      for (int b = 0; b < 8; b++) s[31-4*b -: 4] = 4'(m_sbox(b, int'(e[47-6*b -: 6])));
      for (int i = 0; i < 32; i++) p[31-i] = s[32-M_P[i]];
      t = r; r = l ^ p; l = t;
    end
    x = {r, l};
    for (int i = 0; i < 64; i++) y[63-i] = x[64-M_FP[i]];
    return y;
  endfunction

  function automatic logic [63:0] m_tdes(bit enc, logic [1:0] km,
                                         logic [63:0] k1, k2, k3, blk);
    logic [63:0] k2e, k3e;
    k2e = km[1] ? k1 : k2;
    k3e = (km == 2'b00) ? k3 : k1;
    if (enc) return m_des(k3e, m_des(k2e, m_des(k1, blk, 1), 0), 1);
    return m_des(k1, m_des(k2e, m_des(k3e, blk, 0), 1), 0);
  endfunction

  // ---------------- check helpers ----------------
  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check1(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // drive at negedge, accept on next posedge, return at the negedge after it
  task automatic launch(bit enc, logic [1:0] km, logic [63:0] k1, k2, k3, d);
    @(negedge clk_i);
    start_i = 1'b1; encrypt_i = enc; key_mode_i = km;
    key1_i = k1; key2_i = k2; key3_i = k3; data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    // R10: scramble inputs after acceptance
    encrypt_i = ~enc; key_mode_i = ~km;
    key1_i = rnd64(); key2_i = rnd64(); key3_i = rnd64(); data_i = rnd64();
  endtask

  task automatic wait_pre(int n);
    repeat (n) @(negedge clk_i);
    check1("R6", "done before latency", done_o, 1'b0);
  endtask

  task automatic wait_post(string req, logic [63:0] exp);
    logic [63:0] held;
    @(negedge clk_i);
    check1("R6", "done at latency", done_o, 1'b1);
    check64(req, "result", data_o, exp);
    start_i = 1'b0;
    held = data_o;
    @(negedge clk_i);
    check1("R6", "done single cycle", done_o, 1'b0);
    check64("R7", "result held", data_o, held);
  endtask

  task automatic run_op(string req, bit enc, logic [1:0] km,
                        logic [63:0] k1, k2, k3, d, logic [63:0] exp);
    launch(enc, km, k1, k2, k3, d);
    wait_pre(47);
    wait_post(req, exp);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h1ce_5eed));
    repeat (3) @(negedge clk_i);
    check1("R9", "done after reset", done_o, 1'b0);
    check64("R9", "data after reset", data_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 fixed single-DES answers
    run_op("R4", 1, 2'b10, 64'h133457799BBCDFF1, rnd64(), rnd64(),
           64'h0123456789ABCDEF, 64'h85E813540F0AB405);
    run_op("R4", 0, 2'b11, 64'h133457799BBCDFF1, rnd64(), rnd64(),
           64'h85E813540F0AB405, 64'h0123456789ABCDEF);
    run_op("R4", 1, 2'b10, 64'h0E329232EA6D0D73, rnd64(), rnd64(),
           64'h8787878787878787, 64'h0);
    // R5 all-zero key equals all-parity-bits key
    run_op("R5", 1, 2'b11, 64'h0, rnd64(), rnd64(), 64'h0, 64'h8CA64DE9C1B123A7);
    begin
      logic [63:0] k1 = rnd64(), k2 = rnd64(), k3 = rnd64(), d = rnd64();
      run_op("R5", 1, 2'b00, k1 ^ 64'h0101010101010101, k2 ^ 64'h0001000100010001,
             k3 ^ 64'h0100000000000001, d, m_tdes(1, 2'b00, k1, k2, k3, d));
    end

    // R1 / R2 directed three-key round trip
    begin
      logic [63:0] k1 = rnd64(), k2 = rnd64(), k3 = rnd64(), d = rnd64(), ct;
      ct = m_tdes(1, 2'b00, k1, k2, k3, d);
      run_op("R1", 1, 2'b00, k1, k2, k3, d, ct);
      run_op("R2", 0, 2'b00, k1, k2, k3, ct, d);
      // R3 two-key ignores key3, matches three-key with key3=key1
      run_op("R3", 1, 2'b01, k1, k2, rnd64(), d, m_tdes(1, 2'b00, k1, k2, k1, d));
    end

    // random mix of directions and keying options
    for (int n = 0; n < 40; n++) begin
      bit enc = 1'($urandom());
      logic [1:0] km = 2'($urandom());
      logic [63:0] k1 = rnd64(), k2 = rnd64(), k3 = rnd64(), d = rnd64();
      run_op(enc ? (km == 2'b00 ? "R1" : (km == 2'b01 ? "R3" : "R4")) : "R2",
             enc, km, k1, k2, k3, d, m_tdes(enc, km, k1, k2, k3, d));
    end

    // R8 start in mid-operation is ignored
    begin
      logic [63:0] k1 = rnd64(), k2 = rnd64(), k3 = rnd64(), d = rnd64();
      bit quiet = 1'b1;
      launch(1, 2'b00, k1, k2, k3, d);
      repeat (10) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      wait_pre(36);
      wait_post("R8", m_tdes(1, 2'b00, k1, k2, k3, d));
      repeat (60) begin
        @(negedge clk_i);
        if (done_o !== 1'b0) quiet = 1'b0;
      end
      check1("R8", "no done from ignored start", quiet, 1'b1);
    end

    // R8 back-to-back with new key and direction
    begin
      logic [63:0] a1 = rnd64(), a2 = rnd64(), a3 = rnd64(), ad = rnd64();
      logic [63:0] b1 = rnd64(), b2 = rnd64(), b3 = rnd64(), bd = rnd64();
      launch(1, 2'b00, a1, a2, a3, ad);
      wait_pre(47);
      start_i = 1'b1; encrypt_i = 1'b0; key_mode_i = 2'b01;
      key1_i = b1; key2_i = b2; key3_i = b3; data_i = bd;
      @(negedge clk_i);
      check1("R6", "first done", done_o, 1'b1);
      check64("R8", "first result", data_o, m_tdes(1, 2'b00, a1, a2, a3, ad));
      start_i = 1'b0;
      key1_i = rnd64(); data_i = rnd64(); encrypt_i = 1'b1;
      wait_pre(47);
      wait_post("R8", m_tdes(0, 2'b01, b1, b2, b3, bd));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule